// File: doc/BRIEF.md
# Distributed Dual-Pair Signature Voter

This block supervises two local processors that run the same program in lockstep. At every vote point both processors present an execution signature. The voter compares the two. As long as they agree, the processors run on. When they differ, the voter stops both processors in the same cycle. Two values cannot show which processor is wrong, so the voter then asks a twin voter on another device for that voter's pair of signatures.

The twin voter receives the request, stops its own pair and answers with its two signatures. With four values in hand, the requesting voter looks for the single processor whose signature differs from the other three, which all agree. It reports that processor on a fault index with a one-cycle valid strobe. If no such processor exists, it raises an unrecoverable flag. If the twin does not answer within a bounded window, it raises a link-failure flag. In every one of these outcomes the processors stay stopped until an external recovery controller pulses the release input.

The peer link is a plain parallel word interface. It has a request bit, a response bit and two signature words. Both directions of the link can be active in the same cycle, which means two voters that detect a mismatch at the same moment can still serve each other.

Top module: `sig_pair_voter`

## Requirements
- R1: After reset the stop outputs are low, no request or response is sent, the fault strobe is low, the fault index is 0, and the unrecoverable and link-failure flags are low.
- R2: When the voter is running (stop low), a vote strobe with equal signatures and no incoming request leaves stop low and sends no request.
- R3: When the voter is running, a vote strobe with unequal signatures raises both stop outputs in the next cycle. It also sends a request (`peer_tx_req` high) for exactly one cycle, in that same next cycle.
- R4: An incoming request in any state is answered in the next cycle with `peer_tx_rsp` high. `peer_tx_sig0` carries processor 0's held signature and `peer_tx_sig1` carries processor 1's held signature. While running, the signatures that arrive with a vote strobe in the same cycle are sent instead. While running, an incoming request also raises stop. When no response is sent, both signature words are 0.
- R5: A response that arrives while a request is pending is voted with local processor 0 as index 0, local processor 1 as index 1, `peer_rx_sig0` as index 2 and `peer_rx_sig1` as index 3. If exactly one index differs from the other three and those three agree, `fault_valid` pulses for one cycle in the next cycle, and `fault_idx` shows that index until release.
- R6: If the vote of R5 finds no such single outlier, `unrecoverable` rises in the next cycle, no fault strobe is given, and stop stays high.
- R7: While a request is pending, a response is accepted in any of the RESP_TIMEOUT cycles after the request cycle. If none arrives, `link_fail` rises after exactly RESP_TIMEOUT cycles, and stop stays high.
- R8: Stop stays high until a release pulse arrives after the outcome is settled. That release drops stop and clears the fault index, `unrecoverable` and `link_fail` in the next cycle. A release pulse while a response is still pending, or while running, has no effect.
- R9: A mismatch and an incoming request in the same cycle produce a request and a response together in the next cycle. A request that arrives while a response is pending is answered without leaving the wait.
- R10: After a stop, further vote strobes do not change the held signatures that later responses carry.
- R11: A response that arrives while no request is pending is ignored. Stop, the fault strobe and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vote_strobe | input | 1 | Both signatures valid at a vote point |
| sig_p0 | input | SIG_W | Signature of local processor 0 |
| sig_p1 | input | SIG_W | Signature of local processor 1 |
| stop_p0 | output | 1 | Stop for local processor 0 |
| stop_p1 | output | 1 | Stop for local processor 1 |
| peer_tx_req | output | 1 | Request to the twin voter |
| peer_tx_rsp | output | 1 | Response to the twin voter |
| peer_tx_sig0 | output | SIG_W | Response word, local processor 0 |
| peer_tx_sig1 | output | SIG_W | Response word, local processor 1 |
| peer_rx_req | input | 1 | Request from the twin voter |
| peer_rx_rsp | input | 1 | Response from the twin voter |
| peer_rx_sig0 | input | SIG_W | Twin's processor 0 signature |
| peer_rx_sig1 | input | SIG_W | Twin's processor 1 signature |
| recover_pulse | input | 1 | Release from the recovery controller |
| fault_valid | output | 1 | One-cycle strobe for a located fault |
| fault_idx | output | 2 | Index of the faulty processor |
| unrecoverable | output | 1 | No single outlier found |
| link_fail | output | 1 | Twin did not answer in time |

## Verification
The bench targets the response that arrives on the last cycle of the timeout window. A counter that is off by one would either reject this response or raise `link_fail` one cycle early. It also drives a mismatch and an incoming request in the same cycle, and a request while a response is pending. A voter that cannot send both messages at once, or that drops a request while it waits, would leave its twin without an answer until the timeout. Vote cases cover an outlier at each local index, a split twin pair, and a twin pair that agrees with neither local processor. A wrong vote shows up as the wrong index or as a missing unrecoverable flag. Release pulses during the wait, vote strobes after a stop, and a stray response while running each check that the voter does not free the processors early, does not overwrite the signatures it holds, and does not act on a response nobody requested.

// File: rtl/sig_voter_pkg.sv
package sig_voter_pkg;

  typedef enum logic [1:0] {
    VS_RUN  = 2'd0,
    VS_WAIT = 2'd1,
    VS_HALT = 2'd2
  } vstate_e;

  typedef struct packed {
    logic       resolved;
    logic [1:0] culprit;
  } verdict_t;

  // Turn the per-processor "lone outlier" flags into a verdict.
  function automatic verdict_t lone_to_verdict(input logic [3:0] lone);
    verdict_t v;
    v.resolved = $onehot(lone);
    v.culprit  = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (lone[i]) v.culprit = 2'(i);
    end
    return v;
  endfunction

endpackage

// File: rtl/vt_capture.sv
module vt_capture #(
  parameter int SIG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             strobe,
  input  logic [SIG_W-1:0] sig_a,
  input  logic [SIG_W-1:0] sig_b,
  output logic [SIG_W-1:0] held_a,
  output logic [SIG_W-1:0] held_b,
  output logic [SIG_W-1:0] cur_a,
  output logic [SIG_W-1:0] cur_b,
  output logic             mismatch_evt
);
  logic take;
  assign take = enable && strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_a <= '0;
      held_b <= '0;
    end else if (take) begin
      held_a <= sig_a;
      held_b <= sig_b;
    end
  end

  assign cur_a        = take ? sig_a : held_a;
  assign cur_b        = take ? sig_b : held_b;
  assign mismatch_evt = take && (sig_a != sig_b);
endmodule

// File: rtl/vt_window.sv
module vt_window #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/vt_vote4.sv
module vt_vote4
  import sig_voter_pkg::*;
#(
  parameter int SIG_W = 32
) (
  input  logic [3:0][SIG_W-1:0] sigs,
  output logic [3:0]            lone,
  output verdict_t              verdict
);
  // Processor i is a lone outlier when the other three agree and i differs.
  for (genvar i = 0; i < 4; i++) begin : g_lone
    localparam int J = (i + 1) % 4;
    localparam int K = (i + 2) % 4;
    localparam int L = (i + 3) % 4;
    logic others_agree;
    assign others_agree = (sigs[J] == sigs[K]) && (sigs[K] == sigs[L]);
    assign lone[i]      = others_agree && (sigs[i] != sigs[J]);
  end

  assign verdict = lone_to_verdict(lone);
endmodule

// File: rtl/sig_pair_voter.sv
module sig_pair_voter
  import sig_voter_pkg::*;
#(
  parameter int SIG_W        = 32,
  parameter int RESP_TIMEOUT = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vote_strobe,
  input  logic [SIG_W-1:0] sig_p0,
  input  logic [SIG_W-1:0] sig_p1,
  output logic             stop_p0,
  output logic             stop_p1,
  output logic             peer_tx_req,
  output logic             peer_tx_rsp,
  output logic [SIG_W-1:0] peer_tx_sig0,
  output logic [SIG_W-1:0] peer_tx_sig1,
  input  logic             peer_rx_req,
  input  logic             peer_rx_rsp,
  input  logic [SIG_W-1:0] peer_rx_sig0,
  input  logic [SIG_W-1:0] peer_rx_sig1,
  input  logic             recover_pulse,
  output logic             fault_valid,
  output logic [1:0]       fault_idx,
  output logic             unrecoverable,
  output logic             link_fail
);
  vstate_e state_q, state_d;

  // Named internal events
  logic in_run, in_wait, in_halt;
  logic mismatch_evt, rsp_taken, wait_expired, release_taken;
  logic vote_fault, vote_unrec;
  logic [SIG_W-1:0] held_a, held_b, cur_a, cur_b;
  logic [3:0][SIG_W-1:0] vote_sigs;
  logic [3:0] lone;
  verdict_t verdict;

  // Output registers
  logic             stop_q, tx_req_q, tx_rsp_q, fv_q, unrec_q, lfail_q;
  logic [SIG_W-1:0] tx_s0_q, tx_s1_q;
  logic [1:0]       fidx_q;

  assign in_run  = (state_q == VS_RUN);
  assign in_wait = (state_q == VS_WAIT);
  assign in_halt = (state_q == VS_HALT);

  vt_capture #(.SIG_W(SIG_W)) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (in_run),
    .strobe       (vote_strobe),
    .sig_a        (sig_p0),
    .sig_b        (sig_p1),
    .held_a       (held_a),
    .held_b       (held_b),
    .cur_a        (cur_a),
    .cur_b        (cur_b),
    .mismatch_evt (mismatch_evt)
  );

  assign rsp_taken = in_wait && peer_rx_rsp;

  vt_window #(.LIMIT(RESP_TIMEOUT)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (mismatch_evt),
    .run     (in_wait && !peer_rx_rsp),
    .expired (wait_expired)
  );

  assign vote_sigs[0] = held_a;
  assign vote_sigs[1] = held_b;
  assign vote_sigs[2] = peer_rx_sig0;
  assign vote_sigs[3] = peer_rx_sig1;

  vt_vote4 #(.SIG_W(SIG_W)) u_vote (
    .sigs    (vote_sigs),
    .lone    (lone),
    .verdict (verdict)
  );

  assign vote_fault    = rsp_taken && verdict.resolved;
  assign vote_unrec    = rsp_taken && !verdict.resolved;
  assign release_taken = in_halt && recover_pulse;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      VS_RUN: begin
        if (mismatch_evt)     state_d = VS_WAIT;
        else if (peer_rx_req) state_d = VS_HALT;
      end
      VS_WAIT: begin
        if (rsp_taken || wait_expired) state_d = VS_HALT;
      end
      VS_HALT: begin
        if (recover_pulse) state_d = VS_RUN;
      end
      default: state_d = VS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= VS_RUN;
      stop_q   <= 1'b0;
      tx_req_q <= 1'b0;
      tx_rsp_q <= 1'b0;
      tx_s0_q  <= '0;
      tx_s1_q  <= '0;
      fv_q     <= 1'b0;
      fidx_q   <= 2'd0;
      unrec_q  <= 1'b0;
      lfail_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      stop_q   <= (state_d != VS_RUN);
      tx_req_q <= mismatch_evt;
      tx_rsp_q <= peer_rx_req;
      tx_s0_q  <= peer_rx_req ? cur_a : '0;
      tx_s1_q  <= peer_rx_req ? cur_b : '0;
      fv_q     <= vote_fault;
      if (vote_fault)         fidx_q <= verdict.culprit;
      else if (release_taken) fidx_q <= 2'd0;
      if (vote_unrec)         unrec_q <= 1'b1;
      else if (release_taken) unrec_q <= 1'b0;
      if (wait_expired)       lfail_q <= 1'b1;
      else if (release_taken) lfail_q <= 1'b0;
    end
  end

  assign stop_p0       = stop_q;
  assign stop_p1       = stop_q;
  assign peer_tx_req   = tx_req_q;
  assign peer_tx_rsp   = tx_rsp_q;
  assign peer_tx_sig0  = tx_s0_q;
  assign peer_tx_sig1  = tx_s1_q;
  assign fault_valid   = fv_q;
  assign fault_idx     = fidx_q;
  assign unrecoverable = unrec_q;
  assign link_fail     = lfail_q;
endmodule

// File: rtl/sig_pair_voter_chk.sv
module sig_pair_voter_chk #(
  parameter int SIG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vote_strobe,
  input logic [SIG_W-1:0] sig_p0,
  input logic [SIG_W-1:0] sig_p1,
  input logic             stop_p0,
  input logic             peer_tx_req,
  input logic             peer_tx_rsp,
  input logic             peer_rx_req,
  input logic             recover_pulse,
  input logic             fault_valid,
  input logic             unrecoverable,
  input logic             link_fail,
  input logic             in_halt
);
  a_r2_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_p0 && vote_strobe && sig_p0 == sig_p1 && !peer_rx_req) |=> (!stop_p0 && !peer_tx_req));

  a_r3_mismatch_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_p0 && vote_strobe && sig_p0 != sig_p1) |=> (stop_p0 && peer_tx_req));

  a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    peer_tx_req |=> !peer_tx_req);

  a_r4_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
    peer_rx_req |=> peer_tx_rsp);

  a_r5_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  a_r6_unrec_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |-> (stop_p0 && !fault_valid));

  a_r7_fail_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> (stop_p0 && in_halt));

  a_r8_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p0 && !(in_halt && recover_pulse)) |=> stop_p0);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (in_halt && recover_pulse) |=> !stop_p0);
endmodule

bind sig_pair_voter sig_pair_voter_chk #(.SIG_W(SIG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vote_strobe   (vote_strobe),
  .sig_p0        (sig_p0),
  .sig_p1        (sig_p1),
  .stop_p0       (stop_p0),
  .peer_tx_req   (peer_tx_req),
  .peer_tx_rsp   (peer_tx_rsp),
  .peer_rx_req   (peer_rx_req),
  .recover_pulse (recover_pulse),
  .fault_valid   (fault_valid),
  .unrecoverable (unrecoverable),
  .link_fail     (link_fail),
  .in_halt       (in_halt)
);

// File: tb/tb_sig_pair_voter.sv
module tb_sig_pair_voter;
  localparam int W  = 32;
  localparam int TO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vs = 1'b0, rq = 1'b0, rs = 1'b0, rel = 1'b0;
  logic [W-1:0] a = '0, b = '0, r0 = '0, r1 = '0;
  logic stop0, stop1, txq, txs, fv, unrec, lf;
  logic [W-1:0] ts0, ts1;
  logic [1:0] fidx;

  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  sig_pair_voter #(.SIG_W(W), .RESP_TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .vote_strobe(vs), .sig_p0(a), .sig_p1(b),
    .stop_p0(stop0), .stop_p1(stop1), .peer_tx_req(txq), .peer_tx_rsp(txs),
    .peer_tx_sig0(ts0), .peer_tx_sig1(ts1), .peer_rx_req(rq), .peer_rx_rsp(rs),
    .peer_rx_sig0(r0), .peer_rx_sig1(r1), .recover_pulse(rel),
    .fault_valid(fv), .fault_idx(fidx), .unrecoverable(unrec), .link_fail(lf)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 0;  // 0 running, 1 waiting, 2 halted
  int m_cnt = 0;
  logic [W-1:0] m_h0 = '0, m_h1 = '0;
  logic e_stop = 0, e_req = 0, e_rsp = 0, e_fv = 0, e_un = 0, e_lf = 0;
  logic [W-1:0] e_s0 = '0, e_s1 = '0;
  logic [1:0] e_fi = '0;

  function automatic int ref_vote(input logic [W-1:0] s0, s1, s2, s3);
    logic [W-1:0] s[4];
    int agree[4];
    int zeros = 0, twos = 0, who = -1;
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    for (int i = 0; i < 4; i++) begin
      agree[i] = 0;
      for (int j = 0; j < 4; j++) if (j != i && s[j] == s[i]) agree[i]++;
      if (agree[i] == 0) begin zeros++; who = i; end
      if (agree[i] == 2) twos++;
    end
    return (zeros == 1 && twos == 3) ? who : -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_h0 = '0; m_h1 = '0;
      e_stop = 0; e_req = 0; e_rsp = 0; e_fv = 0; e_un = 0; e_lf = 0;
      e_s0 = '0; e_s1 = '0; e_fi = '0;
    end else begin
      logic [W-1:0] c0, c1;
      int v;
      e_req = 0; e_rsp = 0; e_fv = 0; e_s0 = '0; e_s1 = '0;
      c0 = m_h0; c1 = m_h1;
      if (m_st == 0 && vs) begin c0 = a; c1 = b; end
      if (rq) begin e_rsp = 1; e_s0 = c0; e_s1 = c1; end
      if (m_st == 0) begin
        m_h0 = c0; m_h1 = c1;
        if (vs && a != b) begin e_req = 1; e_stop = 1; m_st = 1; m_cnt = 0; end
        else if (rq) begin e_stop = 1; m_st = 2; end
      end else if (m_st == 1) begin
        if (rs) begin
          v = ref_vote(m_h0, m_h1, r0, r1);
          if (v >= 0) begin e_fv = 1; e_fi = 2'(v); end
          else e_un = 1;
          m_st = 2;
        end else if (m_cnt == TO - 1) begin
          e_lf = 1; m_st = 2;
        end else m_cnt++;
      end else begin
        if (rel) begin e_stop = 0; e_un = 0; e_lf = 0; e_fi = '0; m_st = 0; end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 stop_p0", W'(stop0), W'(e_stop));
      chk("R3 stop_p1 together", W'(stop1), W'(e_stop));
      chk("R3 tx_req", W'(txq), W'(e_req));
      chk("R4 tx_rsp", W'(txs), W'(e_rsp));
      chk("R4 tx_sig0", ts0, e_s0);
      chk("R4 tx_sig1", ts1, e_s1);
      chk("R5 fault_valid", W'(fv), W'(e_fv));
      chk("R5 fault_idx", W'(fidx), W'(e_fi));
      chk("R6 unrecoverable", W'(unrec), W'(e_un));
      chk("R7 link_fail", W'(lf), W'(e_lf));
    end
  end

  // ---------------- stimulus ----------------
  task automatic clr();
    vs = 0; rq = 0; rs = 0; rel = 0; a = '0; b = '0; r0 = '0; r1 = '0;
  endtask

  task automatic drv(input logic v, input logic [W-1:0] pa, pb,
                     input logic q, s, input logic [W-1:0] p0, p1, input logic rl);
    vs = v; a = pa; b = pb; rq = q; rs = s; r0 = p0; r1 = p1; rel = rl;
    @(negedge clk);
    clr();
  endtask

  task automatic idle(input int n);
    clr();
    repeat (n) @(negedge clk);
  endtask

  task automatic release_all();
    drv(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 stop low after release", W'(stop0), 0);
    chk("R8 flags cleared", W'({unrec, lf}), 0);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 stop", W'({stop0, stop1}), 0);
    chk("R1 link idle", W'({txq, txs}), 0);
    chk("R1 flags", W'({fv, fidx, unrec, lf}), 0);

    // R2 matching vote points
    for (int i = 1; i <= 4; i++) begin
      drv(1, W'(i * 17), W'(i * 17), 0, 0, 0, 0, 0);
      chk("R2 no stop on match", W'(stop0), 0);
      chk("R2 no request on match", W'(txq), 0);
    end

    // R11 stray response while running
    drv(0, 0, 0, 0, 1, 32'h5, 32'h6, 0);
    chk("R11 stray response ignored", W'({stop0, fv, unrec, lf}), 0);

    // R5 processor 1 outlier; R8 early release ignored; R10 strobe while waiting
    drv(1, 32'hA, 32'hB, 0, 0, 0, 0, 0);
    chk("R3 stop after mismatch", W'(stop0), 1);
    chk("R3 request sent", W'(txq), 1);
    drv(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 release while waiting ignored", W'(stop0), 1);
    drv(1, 32'h77, 32'h77, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 32'hA, 32'hA, 0);
    chk("R5 fault strobe", W'(fv), 1);
    chk("R5 fault idx 1", W'(fidx), 1);
    idle(1);
    chk("R5 strobe one cycle", W'(fv), 0);
    drv(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R10 held sig0 kept", ts0, 32'hA);
    chk("R10 held sig1 kept", ts1, 32'hB);
    release_all();

    // R5 processor 0 outlier
    drv(1, 32'h5, 32'h2, 0, 0, 0, 0, 0);
    idle(2);
    drv(0, 0, 0, 0, 1, 32'h2, 32'h2, 0);
    chk("R5 fault idx 0", W'(fidx), 0);
    chk("R5 fault strobe idx 0", W'(fv), 1);
    release_all();

    // R6 split twin pair
    drv(1, 32'h3, 32'h4, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 32'h3, 32'h9, 0);
    chk("R6 unrecoverable split twin", W'(unrec), 1);
    chk("R6 no fault strobe", W'(fv), 0);
    idle(3);
    chk("R6 stop held", W'(stop0), 1);
    release_all();

    // R6 twin agrees with neither local processor
    drv(1, 32'h5, 32'h6, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 32'h7, 32'h7, 0);
    chk("R6 unrecoverable no match", W'(unrec), 1);
    release_all();

    // R7 timeout
    drv(1, 32'h1, 32'h2, 0, 0, 0, 0, 0);
    idle(TO - 1);
    chk("R7 no fail before window end", W'(lf), 0);
    idle(1);
    chk("R7 fail at window end", W'(lf), 1);
    chk("R7 stop held", W'(stop0), 1);
    release_all();

    // R7 response on last allowed cycle
    drv(1, 32'h1, 32'h2, 0, 0, 0, 0, 0);
    idle(TO - 1);
    drv(0, 0, 0, 0, 1, 32'h1, 32'h1, 0);
    chk("R7 last-cycle response accepted", W'(fv), 1);
    chk("R7 no fail on last cycle", W'(lf), 0);
    release_all();

    // R4 request while running, no strobe; then request in halt
    drv(1, 32'hC0, 32'hC0, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R4 response sent", W'(txs), 1);
    chk("R4 response sig0", ts0, 32'hC0);
    chk("R4 stop on request", W'(stop0), 1);
    drv(1, 32'hD1, 32'hD2, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R10 strobe after stop ignored", ts1, 32'hC0);
    release_all();

    // R4 request with a matching strobe in the same cycle
    drv(1, 32'hE5, 32'hE5, 1, 0, 0, 0, 0);
    chk("R4 same-cycle signature sent", ts1, 32'hE5);
    chk("R4 same-cycle stop", W'(stop0), 1);
    release_all();

    // R9 crossing requests
    drv(1, 32'h10, 32'h11, 1, 0, 0, 0, 0);
    chk("R9 request and response together", W'({txq, txs}), 2'b11);
    drv(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R9 request answered while waiting", W'(txs), 1);
    chk("R9 still waiting", W'({fv, unrec, lf}), 0);
    drv(0, 0, 0, 0, 1, 32'h20, 32'h21, 0);
    chk("R9 crossing vote unrecoverable", W'(unrec), 1);
    release_all();

    idle(2);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule